// File: doc/BRIEF.md
# Decimal Adjust Unit

This block corrects an 8-bit accumulator byte, with its companion high byte, after binary arithmetic has been done on decimal-coded data. One request carries the low byte, the high byte, the carry and half-carry flags from the preceding arithmetic step, and a 3-bit operation code. The code picks one of five correction rules: packed add, packed subtract, unpacked add, post-multiply split and pre-divide merge. The block returns the corrected bytes and the updated carry and half-carry flags.

Requests enter through a valid/ready handshake. An accepted request produces its result in a register one cycle later. The result is held there until the consumer takes it. A two-state controller governs the output register. `ST_EMPTY` means no result is held. `ST_FULL` means a result is waiting.

The transitions are:
- *take*: `ST_EMPTY` to `ST_FULL` when a request is accepted.
- *refill*: `ST_FULL` stays in `ST_FULL` when the held result is consumed and a new request is accepted on the same edge.
- *drain*: `ST_FULL` to `ST_EMPTY` when the result is consumed and no request is accepted.
- *stall*: `ST_FULL` stays in `ST_FULL` while the consumer is not ready.

Top module: `dec_adjust_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A request accepted on a clock edge (`in_valid` and `in_ready` both 1) presents its result with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, the outputs hold their values unchanged.
- R3: `in_ready` is 1 when no result is held or when `out_ready` is 1, and 0 otherwise. A request offered while `in_ready` is 0 is not taken and never produces a result.
- R4: Code 0 (packed add): let L = (low nibble > 9 or AF) and H = (byte > 99h or CF). The byte gets +06h if L and +60h if H, both judged on the input byte. AF becomes L and CF becomes H. Example: 7Ch becomes 82h with AF=1 and CF=0.
- R5: Code 1 (packed subtract): L and H are the same tests as in R4. The byte gets −06h if L and −60h if H. AF becomes L and CF becomes H. Examples: 2Fh with AF=1 becomes 29h. D7h with CF=1 becomes 77h with CF=1.
- R6: Code 2 (unpacked add): if the low nibble > 9 or AF, the low byte becomes ((byte+6) AND 0Fh), the high byte is incremented, and AF and CF are set. Otherwise the low byte becomes (byte AND 0Fh), the high byte is unchanged, and AF and CF are cleared. The upper nibble of the result byte is always 0.
- R7: Code 3 (split): the high byte becomes byte/10 and the low byte becomes byte mod 10, with the input treated as unsigned binary. CF and AF pass through unchanged. Example: 24h gives 03h and 06h.
- R8: Code 4 (merge): the low byte becomes (high×10 + low) mod 256 and the high byte becomes 0. CF and AF pass through unchanged. Example: digits 2 and 7 give 1Bh.
- R9: Codes 5, 6 and 7 return both bytes and both flags unchanged.
- R10: Codes 0 and 1 leave the high byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The block can take a request this cycle |
| in_op | input | 3 | Correction rule select (0..4; 5..7 pass through) |
| in_al | input | 8 | Low accumulator byte |
| in_ah | input | 8 | High accumulator byte |
| in_cf | input | 1 | Carry flag in |
| in_af | input | 1 | Half-carry flag in |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_al | output | 8 | Corrected low byte |
| out_ah | output | 8 | Corrected high byte |
| out_cf | output | 1 | Carry flag out |
| out_af | output | 1 | Half-carry flag out |

## Verification
The bench drives inputs where both correction terms of the packed rules fire at once, such as 9Ah, which wraps to 00h with the carry set. A design that judged the upper test on the already-corrected byte would miss the +60h there.

An incoming carry or half-carry forces a correction even when the nibble looks like a valid digit. Flag-only cases such as 12h with CF=1 and 37h with AF=1 check this, so a design that looked only at the data would fail them.

The split and merge rules are run at the ends of their ranges (0, 99 and 9-and-9 digits). Codes 5 to 7 check that the flags survive.

The bench stalls the consumer while a second request waits. A design that let that request overwrite the held result would show a changed output, or an extra result the scoreboard did not expect.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    typedef enum logic [2:0] {
        OP_DAA = 3'd0,
        OP_DAS = 3'd1,
        OP_AAA = 3'd2,
        OP_AAM = 3'd3,
        OP_AAD = 3'd4
    } adj_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] al;
        logic [BYTE_W-1:0] ah;
        logic              cf;
        logic              af;
    } adj_word_t;
endpackage

// File: rtl/dadj_packed.sv
// Packed two-digit correction, shared by the add and subtract rules.
module dadj_packed
    import dadj_pkg::*;
(
    input  logic      sub,
    input  adj_word_t a,
    output adj_word_t r
);
    localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(9);
    localparam logic [BYTE_W-1:0] BYTE_MAX = BYTE_W'(8'h99);
    localparam logic [BYTE_W-1:0] LO_K     = BYTE_W'(8'h06);
    localparam logic [BYTE_W-1:0] HI_K     = BYTE_W'(8'h60);

    logic              lo_fix;
    logic              hi_fix;
    logic [BYTE_W-1:0] delta;

    always_comb begin
        // Both tests are judged on the uncorrected byte.
        lo_fix = (a.al[NIB_W-1:0] > NIB_MAX) || a.af;
        hi_fix = (a.al > BYTE_MAX) || a.cf;
        delta  = (lo_fix ? LO_K : '0) + (hi_fix ? HI_K : '0);
        r.al   = sub ? (a.al - delta) : (a.al + delta);
        r.ah   = a.ah;
        r.cf   = hi_fix;
        r.af   = lo_fix;
    end
endmodule

// File: rtl/dadj_unpacked.sv
// One-digit-per-byte corrections: unpacked add, split, merge.
module dadj_unpacked
    import dadj_pkg::*;
(
    input  adj_op_e   op,
    input  adj_word_t a,
    output adj_word_t r
);
    localparam logic [NIB_W-1:0]  NIB_MAX = NIB_W'(9);
    localparam logic [BYTE_W-1:0] RADIX   = BYTE_W'(10);
    localparam logic [BYTE_W-1:0] LO_K    = BYTE_W'(6);

    logic              fix;
    logic [BYTE_W-1:0] bumped;
    logic [BYTE_W-1:0] tens;
    logic [BYTE_W-1:0] units;
    logic [BYTE_W-1:0] merged;

    always_comb begin
        fix    = (a.al[NIB_W-1:0] > NIB_MAX) || a.af;
        bumped = a.al + LO_K;
        tens   = a.al / RADIX;
        units  = a.al % RADIX;
        merged = BYTE_W'(a.ah * RADIX) + a.al;
        r      = a;
        unique case (op)
            OP_AAA: begin
                r.al = {{NIB_W{1'b0}}, (fix ? bumped[NIB_W-1:0] : a.al[NIB_W-1:0])};
                r.ah = a.ah + BYTE_W'(fix);
                r.cf = fix;
                r.af = fix;
            end
            OP_AAM: begin
                r.al = units;
                r.ah = tens;
            end
            OP_AAD: begin
                r.al = merged;
                r.ah = '0;
            end
            default: r = a;
        endcase
    end
endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
    import dadj_pkg::*;
#(
    parameter int OP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [BYTE_W-1:0] in_al,
    input  logic [BYTE_W-1:0] in_ah,
    input  logic              in_cf,
    input  logic              in_af,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_al,
    output logic [BYTE_W-1:0] out_ah,
    output logic              out_cf,
    output logic              out_af
);
    typedef enum logic {ST_EMPTY, ST_FULL} hold_state_e;

    hold_state_e state_q, state_d;
    adj_word_t   req_w, pk_w, up_w, sel_w, res_q;
    adj_op_e     op_e;
    logic        take;

    assign req_w = '{al: in_al, ah: in_ah, cf: in_cf, af: in_af};
    assign op_e  = adj_op_e'(in_op[2:0]);

    dadj_packed u_packed (
        .sub (in_op == OP_W'(OP_DAS)),
        .a   (req_w),
        .r   (pk_w)
    );

    dadj_unpacked u_unpacked (
        .op (op_e),
        .a  (req_w),
        .r  (up_w)
    );

    always_comb begin
        unique case (in_op)
            OP_W'(OP_DAA), OP_W'(OP_DAS): sel_w = pk_w;
            OP_W'(OP_AAA), OP_W'(OP_AAM),
            OP_W'(OP_AAD):                sel_w = up_w;
            default:                      sel_w = req_w;
        endcase
    end

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign take     = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !take) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst)       res_q <= '0;
        else if (take) res_q <= sel_w;
    end

    assign out_valid = (state_q == ST_FULL);
    assign out_al    = res_q.al;
    assign out_ah    = res_q.ah;
    assign out_cf    = res_q.cf;
    assign out_af    = res_q.af;
endmodule

// File: rtl/dadj_checker.sv
module dadj_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [2:0] in_op,
    input logic [7:0] in_al,
    input logic [7:0] in_ah,
    input logic       in_cf,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_al,
    input logic [7:0] out_ah,
    input logic       out_cf,
    input logic       out_af
);
    AST_TAKE_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_al) && $stable(out_ah)
        && $stable(out_cf) && $stable(out_af)); // R2
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready); // R3
    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready); // R3
    AST_PACKED_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op == 3'd0 && in_cf |=> out_cf); // R4
    AST_PACKED_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op == 3'd1 && in_cf |=> out_cf); // R5
    AST_UNPACKED_HIGH_NIB: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op == 3'd2 |=> out_al[7:4] == 4'h0); // R6
    AST_SPLIT_DIGIT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op == 3'd3 |=> out_al < 8'd10 && out_ah < 8'd26); // R7
    AST_MERGE_CLEARS_HIGH: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op == 3'd4 |=> out_ah == 8'h00); // R8
    AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op > 3'd4 |=> out_al == $past(in_al)
        && out_ah == $past(in_ah)); // R9
    AST_PACKED_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_op < 3'd2 |=> out_ah == $past(in_ah)); // R10
endmodule

bind dec_adjust_unit dadj_checker u_dadj_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_al     (in_al),
    .in_ah     (in_ah),
    .in_cf     (in_cf),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_al    (out_al),
    .out_ah    (out_ah),
    .out_cf    (out_cf),
    .out_af    (out_af)
);

// File: tb/dec_adjust_unit_bench.sv
module dec_adjust_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_op = '0;
    logic [7:0] in_al = '0;
    logic [7:0] in_ah = '0;
    logic       in_cf = 1'b0;
    logic       in_af = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_al;
    logic [7:0] out_ah;
    logic       out_cf;
    logic       out_af;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] al;
        logic [7:0] ah;
        logic       cf;
        logic       af;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dec_adjust_unit u_dec_adjust_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_op     (in_op),
        .in_al     (in_al),
        .in_ah     (in_ah),
        .in_cf     (in_cf),
        .in_af     (in_af),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_al    (out_al),
        .out_ah    (out_ah),
        .out_cf    (out_cf),
        .out_af    (out_af)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [2:0] op, input int al, input int ah,
                                   input bit cf, input bit af);
        exp_t e;
        bit lo, hi;
        int v;
        e.al = al[7:0]; e.ah = ah[7:0]; e.cf = cf; e.af = af;
        lo = ((al % 16) > 9) || af;
        hi = (al > 153) || cf;
        case (op)
            3'd0: begin
                v = al + (lo ? 6 : 0) + (hi ? 96 : 0);
                e.al = v[7:0]; e.cf = hi; e.af = lo; e.req = "R4";
            end
            3'd1: begin
                v = al - (lo ? 6 : 0) - (hi ? 96 : 0) + 256;
                e.al = v[7:0]; e.cf = hi; e.af = lo; e.req = "R5";
            end
            3'd2: begin
                v = lo ? ((al + 6) % 16) : (al % 16);
                e.al = v[7:0];
                v = ah + (lo ? 1 : 0);
                e.ah = v[7:0]; e.cf = lo; e.af = lo; e.req = "R6";
            end
            3'd3: begin
                v = al / 10; e.ah = v[7:0];
                v = al % 10; e.al = v[7:0];
                e.req = "R7";
            end
            3'd4: begin
                v = (ah * 10 + al) % 256;
                e.al = v[7:0]; e.ah = 8'h00; e.req = "R8";
            end
            default: e.req = "R9";
        endcase
        return e;
    endfunction

    task automatic send(input logic [2:0] op, input logic [7:0] al, input logic [7:0] ah,
                        input bit cf, input bit af);
        @(negedge clk);
        in_op = op; in_al = al; in_ah = ah; in_cf = cf; in_af = af;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        sb.push_back(model(op, int'(al), int'(ah), cf, af));
        #1 in_valid = 1'b0;
    endtask

    // Monitor: one transfer per negedge sample with valid and ready high.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R3 unexpected result", int'(out_al), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(out_al == e.al && out_ah == e.ah && out_cf == e.cf && out_af == e.af,
                        e.req, int'({out_ah, out_al, 6'b0, out_cf, out_af}),
                        int'({e.ah, e.al, 6'b0, e.cf, e.af}));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after release",
            int'({out_valid, in_ready}), 1);

        // R4 packed add
        send(3'd0, 8'h7C, 8'h11, 0, 0);
        send(3'd0, 8'h9A, 8'h22, 0, 0);
        send(3'd0, 8'h12, 8'h33, 1, 0);
        send(3'd0, 8'h45, 8'h44, 0, 0);
        // R5 packed subtract
        send(3'd1, 8'h2F, 8'h55, 0, 1);
        send(3'd1, 8'hD7, 8'h66, 1, 0);
        send(3'd1, 8'h05, 8'h77, 0, 0);
        // R6 unpacked add
        send(3'd2, 8'h0C, 8'h01, 0, 0);
        send(3'd2, 8'h35, 8'h04, 0, 0);
        send(3'd2, 8'h37, 8'hFF, 0, 1);
        // R7 split
        send(3'd3, 8'h24, 8'h00, 1, 0);
        send(3'd3, 8'h63, 8'h00, 0, 1);
        send(3'd3, 8'h00, 8'h5A, 0, 0);
        send(3'd3, 8'hFF, 8'h00, 0, 0);
        // R8 merge
        send(3'd4, 8'h07, 8'h02, 0, 0);
        send(3'd4, 8'h09, 8'h09, 1, 1);
        // R9 pass through
        send(3'd5, 8'hA5, 8'h3C, 1, 0);
        send(3'd7, 8'h5A, 8'hC3, 0, 1);

        // R2 / R3 stall: hold one result, offer another that must wait
        @(posedge clk);
        #1 out_ready = 1'b0;
        send(3'd0, 8'h7C, 8'h10, 0, 0);
        @(negedge clk);
        in_op = 3'd4; in_al = 8'h01; in_ah = 8'h01; in_valid = 1'b1;
        chk(in_ready == 1'b0, "R3 stall in_ready", int'(in_ready), 0);
        @(negedge clk);
        chk(out_valid == 1'b1 && out_al == 8'h82 && out_ah == 8'h10, "R2 held result",
            int'({out_ah, out_al}), int'({8'h10, 8'h82}));
        chk(in_ready == 1'b0, "R3 still blocked", int'(in_ready), 0);
        in_valid = 1'b0;
        @(posedge clk);
        #1 out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(sb.size() == 0 && out_valid == 1'b0, "R3 nothing extra",
            sb.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule